// File: doc/BRIEF.md
# In-System Serial Programming Host Sequencer

This block is the host side of a four-wire serial programming link to a small target controller. When a session is started it switches on the target supply and holds the target reset line low with the serial clock low. It then pulses reset high, waits for the target to settle and sends the four-byte programming-enable instruction. The byte that comes back while the third instruction byte is on the wire must equal 0x53. If it does not, reset is pulsed again and the enable instruction is sent again, up to a set number of attempts.

Once the target is in programming mode, the block takes a stream of items over a valid/ready interface. Each item is either a program-memory word or a data-EEPROM byte. In write mode, a word is loaded into the target page buffer low byte first, then high byte. A word flagged as closing its page triggers a page commit, which is followed by a silent flash-write wait. Each EEPROM byte is written directly and followed by its own silent wait. When the target is known to be erased, bytes equal to 0xFF are skipped. In verify mode, each location is read back and compared with the item's data, and the first failing address is kept. After the item flagged as last, reset is driven high so that the target runs.

All waits, the reset pulse width, the clock divider and the attempt limit are parameters in system clock cycles.

Top module: `isp_host_seq`

## Requirements
- R1: Out of reset: `tgt_reset` is 1, and `supply_en`, `tgt_sck`, `busy` and `done` are 0.
- R2: After `start`, `supply_en` rises and `tgt_reset` goes low. Reset is pulsed high for RST_PULSE_CYC cycles and then held low. The first SCK rising edge comes at least PWR_WAIT_CYC cycles after that last falling edge of reset.
- R3: The enable instruction is AC 53 00 00 and is always sent in full. Entry to programming mode requires the third received byte to equal 0x53.
- R4: On an echo mismatch, reset is pulsed high and the whole power-up wait and enable instruction are repeated. After MAX_TRIES failed attempts, `enable_fail` and `done` are set and `tgt_reset` returns high.
- R5: Serial framing: 32 bits per instruction, MSB first. MOSI changes only on the falling edge of SCK, and MISO is sampled on the rising edge. Each SCK level lasts SCK_HALF cycles, with SCK_HALF of at least 2.
- R6: A flash word at address A is loaded as 40 00 A[PAGE_W-1:0] lo and then 48 00 A[PAGE_W-1:0] hi. The low byte always goes before the high byte. An item with `item_commit` set is followed by 4C A[15:8] A[7:0]&~mask 00.
- R7: After a page commit, no SCK edge occurs for FLASH_WAIT_CYC cycles.
- R8: An EEPROM byte is written as C0 00 A[7:0] data. After it, no SCK edge occurs for EE_WAIT_CYC cycles.
- R9: With `cfg_erased` = 1 in write mode, no load or EEPROM write carrying data 0xFF is sent. The other bytes are sent.
- R10: With `cfg_verify` = 1, flash bytes are read with 20/28 A[15:8] A[7:0] 00 and EEPROM with A0 00 A[7:0] 00. The fourth received byte is compared with the item data. The first mismatch sets `verify_bad` and holds its address in `verify_addr` until the next `start`.
- R11: After the item with `item_last`, `tgt_reset` goes high and `done` is set. `busy` is 0 while `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a session (accepted when not busy) |
| cfg_verify | input | 1 | 1: read back and compare instead of writing |
| cfg_erased | input | 1 | 1: target is erased, skip 0xFF bytes |
| item_valid | input | 1 | Item offered |
| item_ready | output | 1 | Item accepted when both valid and ready are high |
| item_is_ee | input | 1 | 1: EEPROM byte, 0: flash word |
| item_addr | input | ADDR_W | Word or byte address |
| item_data | input | 16 | Flash word, or EEPROM byte in bits 7:0 |
| item_commit | input | 1 | Flash word closes its page |
| item_last | input | 1 | Final item of the session |
| supply_en | output | 1 | Target supply switch |
| tgt_reset | output | 1 | Target reset pin level |
| tgt_sck | output | 1 | Serial clock |
| tgt_mosi | output | 1 | Serial data to target |
| tgt_miso | input | 1 | Serial data from target |
| busy | output | 1 | Session in progress |
| done | output | 1 | Session finished (pass or fail) |
| enable_fail | output | 1 | Programming enable never acknowledged |
| verify_bad | output | 1 | A verify compare failed |
| verify_addr | output | ADDR_W | Address of the first failing compare |

## Verification
The bench runs a behavioural target that echoes the enable instruction only after a chosen number of refusals. It goes after the retry path: a sequencer that miscounts attempts would give up early or keep going, and one that skipped the reset pulse would resend into a target that is out of step. The target logs any instruction whose high byte arrives before its low byte, and any SCK edge inside a flash or EEPROM write window or inside the power-up wait. These cover designs that reorder loads, shorten waits or swap the two wait lengths. Erased and non-erased sessions with many 0xFF bytes catch a skip rule that is inverted or missing. A verify pass with two planted faults catches a design that keeps the last failing address instead of the first.

// File: rtl/isp_host_pkg.sv
// Shared opcodes, state encoding and the operation record passed from
// the operation builder to the session sequencer.
package isp_host_pkg;

    localparam logic [7:0] OP_ENABLE  = 8'hAC;
    localparam logic [7:0] ENABLE_KEY = 8'h53;
    localparam logic [7:0] OP_LOAD_LO = 8'h40;
    localparam logic [7:0] OP_LOAD_HI = 8'h48;
    localparam logic [7:0] OP_PAGE_WR = 8'h4C;
    localparam logic [7:0] OP_READ_LO = 8'h20;
    localparam logic [7:0] OP_READ_HI = 8'h28;
    localparam logic [7:0] OP_EE_WR   = 8'hC0;
    localparam logic [7:0] OP_EE_RD   = 8'hA0;

    typedef enum logic [3:0] {
        S_IDLE, S_PWR, S_PULSE, S_SETTLE, S_EN_WAIT,
        S_FETCH, S_ISSUE, S_SHIFT, S_HOLD, S_DONE, S_FAIL
    } seq_state_e;

    typedef enum logic [1:0] {HOLD_NONE, HOLD_FLASH, HOLD_EE} hold_e;

    typedef struct packed {
        logic        skip;
        logic        rd;
        hold_e       hold;
        logic [31:0] word;
        logic [7:0]  exp;
    } isp_op_t;

endpackage

// File: rtl/isp_shift32.sv
// Four-byte serial shift engine, MSB first.
// Assumes: go is only raised while idle; SCK_HALF >= 2 so SCK stays at
// or below a quarter of the system clock, taken as the target clock.
// MOSI changes on the falling SCK edge, MISO is sampled on the rising
// edge; only the last 16 received bits are kept (echo and data bytes).
module isp_shift32 #(
    parameter int SCK_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic [31:0] tx,
    input  logic        miso,
    output logic        busy,
    output logic        done,
    output logic [15:0] rx,
    output logic        sck,
    output logic        mosi
);
    localparam int HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    logic          active;
    logic [31:0]   sh;
    logic [HW-1:0] half;
    logic [5:0]    bits;

    // shift engine: half-period timing, edge actions, completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sh     <= '0;
            half   <= '0;
            bits   <= '0;
            sck    <= 1'b0;
            mosi   <= 1'b0;
            rx     <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    sh     <= tx;
                    mosi   <= tx[31];
                    sck    <= 1'b0;
                    half   <= '0;
                    bits   <= '0;
                end
            end else if (half == HW'(SCK_HALF - 1)) begin
                half <= '0;
                if (!sck) begin
                    sck  <= 1'b1;
                    rx   <= {rx[14:0], miso};
                    bits <= bits + 6'd1;
                end else begin
                    sck <= 1'b0;
                    if (bits == 6'd32) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        sh   <= {sh[30:0], 1'b0};
                        mosi <= sh[30];
                    end
                end
            end else begin
                half <= half + HW'(1);
            end
        end
    end

    assign busy = active;

    // R5
    mosi_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));
    // R5
    sck_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |=> sck);
    // R5
    sck_low_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sck) && active) |=> !sck);
endmodule

// File: rtl/isp_delay.sv
// Down-counting delay: load a non-zero count, receive a one-cycle
// expiry pulse that many cycles later. Reloading restarts it.
module isp_delay #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] count,
    output logic          expired
);
    logic [CW-1:0] cnt;

    // countdown with expiry on the final step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (load) begin
                cnt <= count;
            end else if (cnt != '0) begin
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) expired <= 1'b1;
            end
        end
    end

    // R7
    load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (count != '0));
    // R8
    no_early_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !expired);
endmodule

// File: rtl/isp_op_build.sv
// Builds the serial instruction for one step (0..2) of the current item.
// Pure combinational; assumes ADDR_W <= 16 and PAGE_W < 8.
module isp_op_build
    import isp_host_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 4
) (
    input  logic              verify,
    input  logic              erased,
    input  logic              is_ee,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       data,
    input  logic              commit,
    input  logic [1:0]        step,
    output isp_op_t           op
);
    localparam logic [15:0] PMASK = 16'((1 << PAGE_W) - 1);

    logic [15:0] a16;
    logic [7:0]  lo, hi;

    assign a16 = 16'(addr);
    assign lo  = data[7:0];
    assign hi  = data[15:8];

    // per-mode, per-step instruction selection
    always_comb begin
        op = '{skip: 1'b1, rd: 1'b0, hold: HOLD_NONE, word: '0, exp: '0};
        unique case ({verify, is_ee})
            2'b00: begin
                if (step == 2'd0) begin
                    op.skip = erased && (lo == 8'hFF);
                    op.word = {OP_LOAD_LO, 8'h00, a16[7:0] & PMASK[7:0], lo};
                end else if (step == 2'd1) begin
                    op.skip = erased && (hi == 8'hFF);
                    op.word = {OP_LOAD_HI, 8'h00, a16[7:0] & PMASK[7:0], hi};
                end else if (step == 2'd2) begin
                    op.skip = !commit;
                    op.hold = HOLD_FLASH;
                    op.word = {OP_PAGE_WR, a16[15:8], a16[7:0] & ~PMASK[7:0], 8'h00};
                end
            end
            2'b01: begin
                if (step == 2'd0) begin
                    op.skip = erased && (lo == 8'hFF);
                    op.hold = HOLD_EE;
                    op.word = {OP_EE_WR, 8'h00, a16[7:0], lo};
                end
            end
            2'b10: begin
                if (step == 2'd0) begin
                    op.skip = 1'b0;
                    op.rd   = 1'b1;
                    op.exp  = lo;
                    op.word = {OP_READ_LO, a16[15:8], a16[7:0], 8'h00};
                end else if (step == 2'd1) begin
                    op.skip = 1'b0;
                    op.rd   = 1'b1;
                    op.exp  = hi;
                    op.word = {OP_READ_HI, a16[15:8], a16[7:0], 8'h00};
                end
            end
            default: begin
                if (step == 2'd0) begin
                    op.skip = 1'b0;
                    op.rd   = 1'b1;
                    op.exp  = lo;
                    op.word = {OP_EE_RD, 8'h00, a16[7:0], 8'h00};
                end
            end
        endcase
    end
endmodule

// File: rtl/isp_host_seq.sv
// Session sequencer for serial in-system programming of a target.
// Powers the target, forces reset/SCK low, pulses reset, waits, enables
// programming with echo check and bounded retry, then walks an item
// stream through load/commit/write or read/compare steps, and finally
// releases reset. Assumes all wait parameters are >= 1 and SCK_HALF >= 2.
module isp_host_seq
    import isp_host_pkg::*;
#(
    parameter int ADDR_W         = 10,
    parameter int PAGE_W         = 4,
    parameter int SCK_HALF       = 2,
    parameter int RST_PULSE_CYC  = 4,
    parameter int PWR_WAIT_CYC   = 160000,
    parameter int FLASH_WAIT_CYC = 36000,
    parameter int EE_WAIT_CYC    = 72000,
    parameter int MAX_TRIES      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_verify,
    input  logic              cfg_erased,
    input  logic              item_valid,
    output logic              item_ready,
    input  logic              item_is_ee,
    input  logic [ADDR_W-1:0] item_addr,
    input  logic [15:0]       item_data,
    input  logic              item_commit,
    input  logic              item_last,
    output logic              supply_en,
    output logic              tgt_reset,
    output logic              tgt_sck,
    output logic              tgt_mosi,
    input  logic              tgt_miso,
    output logic              busy,
    output logic              done,
    output logic              enable_fail,
    output logic              verify_bad,
    output logic [ADDR_W-1:0] verify_addr
);
    localparam int MAX_A  = (PWR_WAIT_CYC > FLASH_WAIT_CYC) ? PWR_WAIT_CYC : FLASH_WAIT_CYC;
    localparam int MAX_B  = (EE_WAIT_CYC > RST_PULSE_CYC) ? EE_WAIT_CYC : RST_PULSE_CYC;
    localparam int MAX_W  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAX_W + 1);
    localparam int TW     = $clog2(MAX_TRIES + 1);
    localparam logic [31:0] ENABLE_WORD = {OP_ENABLE, ENABLE_KEY, 16'h0000};

    seq_state_e        state;
    logic [TW-1:0]     tries;
    logic              verify_q, erased_q;
    logic              it_ee, it_commit, it_last;
    logic [ADDR_W-1:0] it_addr;
    logic [15:0]       it_data;
    logic [1:0]        step;
    isp_op_t           op;

    logic              sh_go, sh_busy, sh_done;
    logic [15:0]       sh_rx;
    logic [31:0]       sh_tx;
    logic              tmr_load, tmr_exp;
    logic [CW-1:0]     tmr_val;
    logic              echo_ok, last_try, idle_like;

    isp_op_build #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) op_i (
        .verify(verify_q), .erased(erased_q), .is_ee(it_ee), .addr(it_addr),
        .data(it_data), .commit(it_commit), .step(step), .op(op)
    );

    isp_shift32 #(.SCK_HALF(SCK_HALF)) shift_i (
        .clk(clk), .rst_n(rst_n), .go(sh_go), .tx(sh_tx), .miso(tgt_miso),
        .busy(sh_busy), .done(sh_done), .rx(sh_rx), .sck(tgt_sck), .mosi(tgt_mosi)
    );

    isp_delay #(.CW(CW)) delay_i (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .count(tmr_val), .expired(tmr_exp)
    );

    assign echo_ok    = (sh_rx[15:8] == ENABLE_KEY);
    assign last_try   = (tries == TW'(MAX_TRIES - 1));
    assign idle_like  = (state == S_IDLE) || (state == S_DONE) || (state == S_FAIL);
    assign item_ready = (state == S_FETCH);
    assign busy       = !idle_like;
    assign sh_tx      = (state == S_SETTLE) ? ENABLE_WORD : op.word;

    // timer loads and shift launches for the current state and events
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_go    = 1'b0;
        unique case (state)
            S_IDLE, S_DONE, S_FAIL: if (start) begin
                tmr_load = 1'b1; tmr_val = CW'(RST_PULSE_CYC);
            end
            S_PWR: if (tmr_exp) begin
                tmr_load = 1'b1; tmr_val = CW'(RST_PULSE_CYC);
            end
            S_PULSE: if (tmr_exp) begin
                tmr_load = 1'b1; tmr_val = CW'(PWR_WAIT_CYC);
            end
            S_SETTLE: sh_go = tmr_exp;
            S_EN_WAIT: if (sh_done && !echo_ok && !last_try) begin
                tmr_load = 1'b1; tmr_val = CW'(RST_PULSE_CYC);
            end
            S_ISSUE: sh_go = (step != 2'd3) && !op.skip;
            S_SHIFT: if (sh_done && op.hold != HOLD_NONE) begin
                tmr_load = 1'b1;
                tmr_val  = (op.hold == HOLD_FLASH) ? CW'(FLASH_WAIT_CYC) : CW'(EE_WAIT_CYC);
            end
            default: ;
        endcase
    end

    // session state machine, pin levels, item latch and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            supply_en   <= 1'b0;
            tgt_reset   <= 1'b1;
            tries       <= '0;
            verify_q    <= 1'b0;
            erased_q    <= 1'b0;
            it_ee       <= 1'b0;
            it_commit   <= 1'b0;
            it_last     <= 1'b0;
            it_addr     <= '0;
            it_data     <= '0;
            step        <= '0;
            done        <= 1'b0;
            enable_fail <= 1'b0;
            verify_bad  <= 1'b0;
            verify_addr <= '0;
        end else begin
            unique case (state)
                S_IDLE, S_DONE, S_FAIL: if (start) begin
                    state       <= S_PWR;
                    supply_en   <= 1'b1;
                    tgt_reset   <= 1'b0;
                    tries       <= '0;
                    done        <= 1'b0;
                    enable_fail <= 1'b0;
                    verify_bad  <= 1'b0;
                    verify_addr <= '0;
                    verify_q    <= cfg_verify;
                    erased_q    <= cfg_erased;
                end
                S_PWR: if (tmr_exp) begin
                    state     <= S_PULSE;
                    tgt_reset <= 1'b1;
                end
                S_PULSE: if (tmr_exp) begin
                    state     <= S_SETTLE;
                    tgt_reset <= 1'b0;
                end
                S_SETTLE: if (tmr_exp) state <= S_EN_WAIT;
                S_EN_WAIT: if (sh_done) begin
                    if (echo_ok) begin
                        state <= S_FETCH;
                    end else begin
                        tries     <= tries + TW'(1);
                        tgt_reset <= 1'b1;
                        if (last_try) begin
                            state       <= S_FAIL;
                            enable_fail <= 1'b1;
                            done        <= 1'b1;
                        end else begin
                            state <= S_PULSE;
                        end
                    end
                end
                S_FETCH: if (item_valid) begin
                    it_ee     <= item_is_ee;
                    it_addr   <= item_addr;
                    it_data   <= item_data;
                    it_commit <= item_commit;
                    it_last   <= item_last;
                    step      <= 2'd0;
                    state     <= S_ISSUE;
                end
                S_ISSUE: begin
                    if (step == 2'd3) begin
                        if (it_last) begin
                            state     <= S_DONE;
                            tgt_reset <= 1'b1;
                            done      <= 1'b1;
                        end else begin
                            state <= S_FETCH;
                        end
                    end else if (op.skip) begin
                        step <= step + 2'd1;
                    end else begin
                        state <= S_SHIFT;
                    end
                end
                S_SHIFT: if (sh_done) begin
                    if (op.rd && (sh_rx[7:0] != op.exp) && !verify_bad) begin
                        verify_bad  <= 1'b1;
                        verify_addr <= it_addr;
                    end
                    if (op.hold != HOLD_NONE) begin
                        state <= S_HOLD;
                    end else begin
                        step  <= step + 2'd1;
                        state <= S_ISSUE;
                    end
                end
                S_HOLD: if (tmr_exp) begin
                    step  <= step + 2'd1;
                    state <= S_ISSUE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R11
    done_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tgt_reset && !busy));
    // R7
    hold_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |-> (!tgt_sck && !sh_busy));
    // R2
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SETTLE) |-> (!tgt_reset && !tgt_sck && supply_en));
    // R4
    fail_after_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(enable_fail) |-> (tries == TW'(MAX_TRIES)));
    // R6
    ready_idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        item_ready |-> !sh_busy);
    // R10
    first_bad_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (verify_bad && !(start && idle_like)) |=> (verify_bad && $stable(verify_addr)));
endmodule

// File: tb/isp_host_seq_tb_top.sv
module isp_host_seq_tb_top;
    localparam int ADDR_W = 10, PAGE_W = 4, SCK_HALF = 2, RST_PULSE = 4;
    localparam int PWR_W = 40, FL_W = 60, EE_W = 30, TRIES = 3;
    localparam int NFW = 32, NEE = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, cfg_verify = 0, cfg_erased = 0;
    logic item_valid = 0, item_is_ee = 0, item_commit = 0, item_last = 0;
    logic [ADDR_W-1:0] item_addr = '0;
    logic [15:0] item_data = '0;
    logic item_ready, supply_en, tgt_reset, tgt_sck, tgt_mosi, tgt_miso;
    logic busy, done, enable_fail, verify_bad;
    logic [ADDR_W-1:0] verify_addr;

    int n_tests = 0, n_fail = 0;
    longint cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    isp_host_seq #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SCK_HALF(SCK_HALF),
        .RST_PULSE_CYC(RST_PULSE), .PWR_WAIT_CYC(PWR_W), .FLASH_WAIT_CYC(FL_W),
        .EE_WAIT_CYC(EE_W), .MAX_TRIES(TRIES)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_verify(cfg_verify),
        .cfg_erased(cfg_erased), .item_valid(item_valid), .item_ready(item_ready),
        .item_is_ee(item_is_ee), .item_addr(item_addr), .item_data(item_data),
        .item_commit(item_commit), .item_last(item_last), .supply_en(supply_en),
        .tgt_reset(tgt_reset), .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi),
        .tgt_miso(tgt_miso), .busy(busy), .done(done), .enable_fail(enable_fail),
        .verify_bad(verify_bad), .verify_addr(verify_addr));

    // ---------------- behavioural target ----------------
    logic [15:0] fmem [0:1023];
    logic [7:0]  emem [0:127];
    logic [7:0]  pb_lo [0:15], pb_hi [0:15];
    logic        pl_ok [0:15], ph_ok [0:15];
    logic [31:0] inw = '0;
    logic [7:0]  outb = '0;
    logic [2:0]  bpos = '0;
    int bitcnt = 0, refuse = 0, en_cnt = 0, loads = 0, ff_loads = 0;
    int ee_wr = 0, ee_ff = 0, order_err = 0, wait_err = 0, pw_err = 0, pulses = 0;
    longint quiet_until = 0, rst_fall = 0;
    logic after_rst = 1'b0;

    assign tgt_miso = outb[~bpos];

    always @(posedge tgt_reset) begin
        bitcnt = 0; bpos = '0; outb = '0; pulses++;
    end
    always @(negedge tgt_reset) begin
        rst_fall = cyc; after_rst = 1'b1;
    end

    always @(posedge tgt_sck) begin
        if (!tgt_reset) begin
            if (bitcnt == 0) begin
                if (cyc < quiet_until) wait_err++;
                if (after_rst && (cyc - rst_fall < PWR_W)) pw_err++;
                after_rst = 1'b0;
            end
            inw = {inw[30:0], tgt_mosi};
            bitcnt++; bpos = bpos + 3'd1;
            if (bpos == 3'd0) begin
                outb = 8'h00;
                if (bitcnt == 16 && inw[15:8] == 8'hAC)
                    outb = (refuse > 0) ? 8'h00 : inw[7:0];
                if (bitcnt == 24) begin
                    case (inw[23:16])
                        8'h20: outb = fmem[{inw[9:8], inw[7:0]}][7:0];
                        8'h28: outb = fmem[{inw[9:8], inw[7:0]}][15:8];
                        8'hA0: outb = emem[inw[6:0]];
                        default: outb = 8'h00;
                    endcase
                end
                if (bitcnt == 32) begin
                    bitcnt = 0;
                    decode(inw);
                end
            end
        end
    end

    task automatic decode(input logic [31:0] w);
        case (w[31:24])
            8'hAC: begin en_cnt++; if (refuse > 0) refuse--; end
            8'h40: begin pb_lo[w[11:8]] = w[7:0]; pl_ok[w[11:8]] = 1'b1;
                   loads++; if (w[7:0] == 8'hFF) ff_loads++; end
            8'h48: begin if (!pl_ok[w[11:8]]) order_err++;
                   pb_hi[w[11:8]] = w[7:0]; ph_ok[w[11:8]] = 1'b1;
                   loads++; if (w[7:0] == 8'hFF) ff_loads++; end
            8'h4C: begin
                for (int i = 0; i < 16; i++) begin
                    if (pl_ok[i] || ph_ok[i])
                        fmem[{w[17:16], w[15:12], 4'(i)}] =
                            {ph_ok[i] ? pb_hi[i] : 8'hFF, pl_ok[i] ? pb_lo[i] : 8'hFF};
                    pl_ok[i] = 1'b0; ph_ok[i] = 1'b0;
                end
                quiet_until = cyc + FL_W;
            end
            8'hC0: begin emem[w[14:8]] = w[7:0]; ee_wr++;
                   if (w[7:0] == 8'hFF) ee_ff++; quiet_until = cyc + EE_W; end
            default: ;
        endcase
    endtask

    // ---------------- SPI framing monitor (R5) ----------------
    logic sck_p = 0, mosi_p = 0;
    int run = 0, frame_err = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sck_p && tgt_sck && (tgt_mosi != mosi_p)) frame_err++;
            if (tgt_sck != sck_p) begin
                if (run < SCK_HALF && busy) frame_err++;
                run = 1;
            end else run++;
        end
        sck_p = tgt_sck; mosi_p = tgt_mosi;
    end

    // ---------------- helpers ----------------
    function automatic logic [7:0] pat_lo(int a);
        return (a % 5 == 0) ? 8'hFF : 8'((a * 37 + 5) & 255);
    endfunction
    function automatic logic [7:0] pat_hi(int a);
        return (a % 7 == 0) ? 8'hFF : 8'((a * 11 + 3) & 255);
    endfunction
    function automatic logic [7:0] pat_ee(int a);
        return (a % 3 == 0) ? 8'hFF : 8'((a * 29 + 1) & 255);
    endfunction

    task automatic check(input string req, input longint act, input longint exp_v);
        n_tests++;
        if (act != exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic put_item(input logic ee, input int a, input logic [15:0] d,
                            input logic cm, input logic last);
        @(negedge clk);
        while (!item_ready) @(negedge clk);
        item_valid = 1; item_is_ee = ee; item_addr = ADDR_W'(a); item_data = d;
        item_commit = cm; item_last = last;
        @(negedge clk);
        item_valid = 0;
    endtask

    task automatic session(input logic ver, input logic ers, input logic feed);
        @(negedge clk);
        cfg_verify = ver; cfg_erased = ers; start = 1;
        @(negedge clk);
        start = 0;
        if (feed) begin
            for (int a = 0; a < NFW; a++)
                put_item(1'b0, a, {pat_hi(a), pat_lo(a)}, (a % 16) == 15, 1'b0);
            for (int a = 0; a < NEE; a++)
                put_item(1'b1, a, {8'h00, pat_ee(a)}, 1'b0, a == NEE - 1);
        end
        while (!done) @(negedge clk);
    endtask

    task automatic reset_counts();
        en_cnt = 0; loads = 0; ff_loads = 0; ee_wr = 0; ee_ff = 0;
        order_err = 0; wait_err = 0; pw_err = 0; pulses = 0; frame_err = 0;
    endtask

    task automatic clear_target(input logic [15:0] fv, input logic [7:0] ev);
        for (int i = 0; i < 1024; i++) fmem[i] = fv;
        for (int i = 0; i < 128; i++) emem[i] = ev;
        for (int i = 0; i < 16; i++) begin pl_ok[i] = 0; ph_ok[i] = 0; end
    endtask

    function automatic int mem_mismatches();
        int m = 0;
        for (int a = 0; a < NFW; a++)
            if (fmem[a] != {pat_hi(a), pat_lo(a)}) m++;
        for (int a = 0; a < NEE; a++)
            if (emem[a] != pat_ee(a)) m++;
        return m;
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int exp_loads, exp_ee;
        clear_target(16'h0000, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 reset", tgt_reset, 1);
        check("R1 supply", supply_en, 0);
        check("R1 sck", tgt_sck, 0);
        check("R1 busy/done", {busy, done}, 0);

        // Session A: two refusals, non-erased write (R2 R3 R4 R5 R6 R7 R8 R11)
        reset_counts(); refuse = 2;
        session(1'b0, 1'b0, 1'b1);
        check("R3 enable attempts", en_cnt, 3);
        check("R4 no fail after late echo", enable_fail, 0);
        check("R4 reset pulses incl release", pulses, 4);
        check("R2 power wait", pw_err, 0);
        check("R5 framing", frame_err, 0);
        check("R6 load order", order_err, 0);
        check("R6 load count", loads, 2 * NFW);
        check("R7 R8 silent waits", wait_err, 0);
        check("R8 ee writes", ee_wr, NEE);
        check("R6 R8 memory content", mem_mismatches(), 0);
        check("R11 release", {tgt_reset, done, busy}, 3'b110);

        // Session B: erased target, 0xFF bytes skipped (R9)
        clear_target(16'hFFFF, 8'hFF); reset_counts();
        session(1'b0, 1'b1, 1'b1);
        exp_loads = 0; exp_ee = 0;
        for (int a = 0; a < NFW; a++) begin
            if (pat_lo(a) != 8'hFF) exp_loads++;
            if (pat_hi(a) != 8'hFF) exp_loads++;
        end
        for (int a = 0; a < NEE; a++) if (pat_ee(a) != 8'hFF) exp_ee++;
        check("R9 load count", loads, exp_loads);
        check("R9 ff loads", ff_loads, 0);
        check("R9 ee writes", ee_wr, exp_ee);
        check("R9 ee ff writes", ee_ff, 0);
        check("R9 memory content", mem_mismatches(), 0);
        check("R7 R8 waits erased", wait_err, 0);

        // Session C: verify clean (R10)
        reset_counts();
        session(1'b1, 1'b0, 1'b1);
        check("R10 clean verify", verify_bad, 0);
        check("R10 no writes", loads + ee_wr, 0);

        // Session D: verify with two faults, first kept (R10)
        fmem[21] = fmem[21] ^ 16'h0100;
        emem[6]  = emem[6] ^ 8'h01;
        session(1'b1, 1'b0, 1'b1);
        check("R10 mismatch flag", verify_bad, 1);
        check("R10 first address", verify_addr, 21);

        // Session E: target never echoes (R4)
        reset_counts(); refuse = 99;
        session(1'b0, 1'b0, 1'b0);
        check("R4 fail flag", enable_fail, 1);
        check("R4 attempts", en_cnt, TRIES);
        check("R4 reset high after fail", tgt_reset, 1);
        check("R3 no programming after fail", loads + ee_wr, 0);
        check("R10 flag cleared by start", verify_bad, 0);
        refuse = 0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule